// File: doc/BRIEF.md
# Reloadable Up-Counter with Snapshot Latch

This block is a register-mapped timer/counter. A host writes a reload value, then picks one of four operating modes: load the counter from the reload value, freeze it, let it count, or let it count only while a gate input is high. The counter is never read directly. The host issues a latch command that copies the live count into a snapshot register, and then reads that snapshot either as one word or as separate bytes.

Counting happens on count events inside the system clock domain. A count event is either a one-cycle internal tick strobe, or a rising edge of an external pulse input that has first passed through a two-flop synchronizer. A control write selects the source. When the counter holds all ones, the next count event loads the reload value instead of wrapping to zero, so the counter can act as a programmable-period divider.

Top module: `tmr_reload_counter`

## Requirements
- R1: After reset the reload value, the counter and the snapshot are all zero, the mode is 00 and the internal tick is the count source; a latch command straight after reset yields 0x0000.
- R2: A word write (wr_word=1) loads all 16 bits of the reload value. A byte write (wr_word=0) loads wr_data[7:0] into the low byte when wr_addr=0 or into the high byte when wr_addr=1, and leaves the other byte unchanged.
- R3: In mode 00, every count event loads the counter from the reload value.
- R4: In mode 01, count events leave the counter unchanged.
- R5: In mode 10, every count event adds one to the counter.
- R6: When the counter holds 0xFFFF and a counting mode sees a count event, the counter takes the reload value, not zero.
- R7: In mode 11, the counter acts as in mode 10 while the synchronized gate_in is high and as in mode 01 while it is low. gate_in passes through two flops before it takes effect.
- R8: A latch command copies the counter value present at that clock edge into the snapshot. The snapshot then keeps its value through any later counting until the next latch command.
- R9: With rd_word=1, rd_data returns the whole snapshot. With rd_word=0, rd_data returns the snapshot's low byte for rd_addr=0 or its high byte for rd_addr=1, zero-extended. Reads do not alter the snapshot.
- R10: With ctl_src_ext=0 (the reset value), each cycle in which int_tick is high is one count event. With ctl_src_ext=1, each rising edge of the synchronized ext_cnt is one count event and int_tick is ignored. ctl_wr loads ctl_mode and ctl_src_ext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Load mode and source select |
| ctl_mode | input | 2 | Mode field: 00 load, 01 hold, 10 run, 11 gated run |
| ctl_src_ext | input | 1 | Count source: 0 internal tick, 1 external pulse |
| wr_en | input | 1 | Reload value write strobe |
| wr_word | input | 1 | 1 for a word write, 0 for a byte write |
| wr_addr | input | 1 | Byte address for byte writes (0 low, 1 high) |
| wr_data | input | 16 | Write data; bits 7:0 are used for byte writes |
| latch_cmd | input | 1 | Copy the live count into the snapshot |
| rd_word | input | 1 | 1 for a word read, 0 for a byte read |
| rd_addr | input | 1 | Byte address for byte reads |
| rd_data | output | 16 | Read data from the snapshot |
| int_tick | input | 1 | Internal count strobe, one system cycle wide |
| ext_cnt | input | 1 | Asynchronous external count pulse |
| gate_in | input | 1 | Asynchronous gate for mode 11 |

## Verification
A control write, a reload write or a latch command takes effect at the next clock edge. An int_tick strobe moves the counter at the edge where it is seen. An ext_cnt rise moves the counter at the third edge after it, and a gate_in change governs ticks from the third edge onward. The bench drives every input on the falling edge. After each external or gate change it waits at least four cycles before the next tick or latch. It then confirms the count only through a latch command issued on the cycle after the count event. A monitor process compares the snapshot half a cycle after the latching edge, against the value that the driver queued when it issued the command.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int unsigned TMR_W = 16;
    localparam int unsigned TMR_BYTES = TMR_W / 8;
    localparam int unsigned TMR_AW = (TMR_BYTES > 1) ? $clog2(TMR_BYTES) : 1;

    typedef enum logic [1:0] {
        MODE_LOAD  = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_RUN   = 2'b10,
        MODE_GATED = 2'b11
    } mode_e;

    typedef struct packed {
        logic [TMR_W-1:0] reload;
        logic [TMR_W-1:0] snap;
        mode_e            mode;
        logic             src_ext;
        logic             ext_prev;
    } regs_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q[STAGES-1];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  mode_e            mode,
    input  logic             gate_lvl,
    input  logic [TMR_W-1:0] reload,
    output logic [TMR_W-1:0] cnt
);
    logic [TMR_W-1:0] cnt_d, cnt_q;
    logic [TMR_W-1:0] adv;

    always_comb begin
        // all-ones rolls to the reload value instead of zero
        adv   = (cnt_q == '1) ? reload : cnt_q + 1'b1;
        cnt_d = cnt_q;
        if (step) begin
            unique case (mode)
                MODE_LOAD:  cnt_d = reload;
                MODE_HOLD:  cnt_d = cnt_q;
                MODE_RUN:   cnt_d = adv;
                MODE_GATED: cnt_d = gate_lvl ? adv : cnt_q;
                default:    cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_reload_counter.sv
module tmr_reload_counter
    import tmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_mode,
    input  logic              ctl_src_ext,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [TMR_AW-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    input  logic              latch_cmd,
    input  logic              rd_word,
    input  logic [TMR_AW-1:0] rd_addr,
    output logic [TMR_W-1:0]  rd_data,
    input  logic              int_tick,
    input  logic              ext_cnt,
    input  logic              gate_in
);
    regs_t            r_d, r_q;
    logic             ext_s, gate_s, step;
    logic [TMR_W-1:0] cnt_w;
    mode_e            cur_mode;
    logic [TMR_W-1:0] cur_reload;
    logic [TMR_W-1:0] cur_snap;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d(ext_cnt), .q(ext_s)
    );

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
        .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_s)
    );

    assign cur_mode   = r_q.mode;
    assign cur_reload = r_q.reload;
    assign cur_snap   = r_q.snap;

    // count event: tick strobe, or rising edge of the synchronized pulse
    assign step = r_q.src_ext ? (ext_s & ~r_q.ext_prev) : int_tick;

    tmr_count_core u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .mode(cur_mode),
        .gate_lvl(gate_s), .reload(cur_reload), .cnt(cnt_w)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ext_prev = ext_s;
        if (ctl_wr) begin
            r_d.mode    = mode_e'(ctl_mode);
            r_d.src_ext = ctl_src_ext;
        end
        if (wr_en) begin
            if (wr_word) begin
                r_d.reload = wr_data;
            end else begin
                for (int b = 0; b < TMR_BYTES; b++) begin
                    if (wr_addr == TMR_AW'(b)) r_d.reload[b*8 +: 8] = wr_data[7:0];
                end
            end
        end
        if (latch_cmd) r_d.snap = cnt_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{reload: '0, snap: '0, mode: MODE_LOAD, src_ext: 1'b0, ext_prev: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_word) begin
            rd_data = r_q.snap;
        end else begin
            for (int b = 0; b < TMR_BYTES; b++) begin
                if (rd_addr == TMR_AW'(b)) rd_data[7:0] = r_q.snap[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/tmr_reload_counter_chk.sv
module tmr_reload_counter_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input mode_e            mode,
    input logic             step,
    input logic             gate_lvl,
    input logic [TMR_W-1:0] cnt,
    input logic [TMR_W-1:0] reload,
    input logic [TMR_W-1:0] snap,
    input logic             latch_cmd
);
    // R3
    load_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_LOAD) |=> cnt == $past(reload));

    // R4
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(cnt));

    // R5
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_RUN && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

    // R6
    overflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '1 && (mode == MODE_RUN || (mode == MODE_GATED && gate_lvl)))
        |=> cnt == $past(reload));

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GATED && !gate_lvl) |=> $stable(cnt));

    // R8
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cmd |=> snap == $past(cnt));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_cmd |=> $stable(snap));

    // R10
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !latch_cmd) |=> $stable(cnt));
endmodule

bind tmr_reload_counter tmr_reload_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .step(step), .gate_lvl(gate_s),
    .cnt(cnt_w), .reload(cur_reload), .snap(cur_snap), .latch_cmd(latch_cmd)
);

// File: tb/tb_tmr_reload_counter.sv
module tb_tmr_reload_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_mode = 2'b00;
    logic        ctl_src_ext = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [0:0]  wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        latch_cmd = 1'b0;
    logic        rd_word = 1'b1;
    logic [0:0]  rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic        int_tick = 1'b0;
    logic        ext_cnt = 1'b0;
    logic        gate_in = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    tmr_reload_counter dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_src_ext(ctl_src_ext), .wr_en(wr_en), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .latch_cmd(latch_cmd),
        .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_tick(int_tick), .ext_cnt(ext_cnt), .gate_in(gate_in)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: after every latching edge, compare the snapshot with the queue
    always begin
        @(posedge clk);
        if (latch_cmd) begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0) begin
                check("latch without expectation", rd_data, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctl(logic [1:0] m, logic src);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_mode = m; ctl_src_ext = src;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_reload(logic word, logic a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_word = word; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        int_tick = 1'b1;
        @(negedge clk);
        int_tick = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_cnt = 1'b1;
        cycles(4);
        ext_cnt = 1'b0;
        cycles(4);
    endtask

    task automatic latch(logic [15:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        latch_cmd = 1'b1;
        @(negedge clk);
        latch_cmd = 1'b0;
    endtask

    task automatic rd(logic word, logic a, logic [15:0] exp, string tag);
        @(negedge clk);
        rd_word = word; rd_addr = a;
        #1;
        check(tag, rd_data, exp);
        rd_word = 1'b1; rd_addr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        rd(1'b1, 1'b0, 16'h0000, "R1 snapshot after reset");
        tick();                                   // mode 00, reload 0
        latch(16'h0000, "R1 counter after reset");

        wr_reload(1'b1, 1'b0, 16'h1234);
        tick();
        latch(16'h1234, "R2 R3 word write then load");

        wr_reload(1'b0, 1'b0, 16'h00FD);
        wr_reload(1'b0, 1'b1, 16'h00FF);
        tick();
        latch(16'hFFFD, "R2 byte writes then load");

        set_ctl(2'b10, 1'b0);
        tick();
        latch(16'hFFFE, "R5 run increment");
        tick();
        latch(16'hFFFF, "R5 run to all ones");
        tick();
        latch(16'hFFFD, "R6 overflow reload");

        rd(1'b0, 1'b0, 16'h00FD, "R9 low byte read");
        rd(1'b0, 1'b1, 16'h00FF, "R9 high byte read");

        tick();
        rd(1'b1, 1'b0, 16'hFFFD, "R8 snapshot holds while counting");
        latch(16'hFFFE, "R8 next latch");

        set_ctl(2'b01, 1'b0);
        tick();
        tick();
        latch(16'hFFFE, "R4 hold mode");

        set_ctl(2'b11, 1'b0);
        tick();
        latch(16'hFFFE, "R7 gate low holds");
        @(negedge clk); gate_in = 1'b1;
        cycles(4);
        tick();
        latch(16'hFFFF, "R7 gate high counts");
        @(negedge clk); gate_in = 1'b0;
        cycles(4);
        tick();
        latch(16'hFFFF, "R7 gate low again");

        set_ctl(2'b10, 1'b1);
        tick();
        latch(16'hFFFF, "R10 int_tick ignored with external source");
        ext_pulse();
        latch(16'hFFFD, "R10 R6 external edge overflows");
        ext_pulse();
        latch(16'hFFFE, "R10 external edge counts");

        wr_reload(1'b0, 1'b1, 16'hAB12);
        set_ctl(2'b00, 1'b0);
        tick();
        latch(16'h12FD, "R2 high byte write keeps low byte");
        rd(1'b0, 1'b1, 16'h0012, "R9 high byte zero-extended");

        cycles(3);
        if (exp_q.size() != 0) check("scoreboard drained", 16'(exp_q.size()), 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule